// File: doc/BRIEF.md
# Halt-Aware Opcode Fetch Sequencer

This block is the fetch and control front end of a small 8-bit processor. It owns the program counter, a 7-bit-counting refresh register and a halted flag. On every clock it runs one machine cycle, which is either an opcode fetch or an interrupt-acknowledge cycle. Any byte other than the halt opcode is treated as a one-byte instruction, so the program counter simply steps past it.

When the halt opcode is executed, the program counter moves on to the byte after the halt and the block enters the halted state. While halted, the fetch bus cycles continue at that following address. The returned byte is discarded and a no-operation is performed in its place. The program counter stays where it is, but the refresh register keeps counting. Software can therefore measure how long the processor was halted by reading the refresh value when the next interrupt arrives.

An accepted maskable interrupt clears the halted flag and presents the current program counter as the return address, without adding one. Execution then continues at the fixed service vector. Because the dummy fetches never touch the halt byte itself, a halt at the last address of a memory region fetches only from the first address of the next region.

Top module: `halt_fetch_seq`

## Requirements
- R1: Synchronous reset (rst high at a clock edge) leaves fetch_addr at 0x0000, halted at 0, refresh at 0x00, irq_ack at 0 and ret_addr at 0x0000. The first cycle after reset is a fetch cycle with fetch_rd high.
- R2: In a fetch cycle that is not halted, is not accepting an interrupt and holds any byte other than 0x76, fetch_addr in the next cycle is the current fetch_addr plus one, modulo 2^16.
- R3: A fetch of opcode 0x76 while not halted, with no interrupt accepted in that cycle, sets halted in the next cycle and moves fetch_addr to the halt address plus one. A halt at 0xFFFF therefore continues at 0x0000.
- R4: While halted, every non-acknowledge cycle has fetch_rd high at an unchanged fetch_addr. The fetched byte is ignored, and a further 0x76 has no effect.
- R5: A halt fetched at 0x7FFF makes all of its dummy fetches read 0x8000 and never 0x7FFF. The return address given at the next interrupt is 0x8000.
- R6: Each fetch cycle (fetch_rd high) increments refresh[6:0] by one, wrapping from 0x7F to 0x00. refresh[7] is never changed by this counting. Acknowledge cycles leave refresh unchanged.
- R7: When irq_req and irq_en are both high in a fetch cycle, the next cycle is an acknowledge cycle. In that cycle irq_ack is high for exactly one cycle, fetch_rd is low, halted is 0 and ret_addr is the address that would have followed the completed cycle: fetch_addr when halted, fetch_addr plus one otherwise. ret_addr holds until the next acceptance. Requests are not sampled during the acknowledge cycle.
- R8: In the acknowledge cycle fetch_addr shows 0x0038, and the cycle after it fetches from 0x0038.
- R9: A request with irq_en low is ignored. A halted sequencer stays halted at the same fetch_addr, and irq_ack stays low.
- R10: The halted output is high from the cycle after a halt is executed until the acknowledge cycle of the interrupt that ends it.
- R11: If a halt opcode is fetched in the same cycle as an accepted interrupt, the interrupt wins. halted stays 0 and ret_addr is the halt address plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one machine cycle per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fetch_addr | output | 16 | Opcode fetch address (the program counter) |
| fetch_rd | output | 1 | High in opcode fetch cycles |
| op_data | input | 8 | Opcode byte returned for the current fetch |
| irq_req | input | 1 | Maskable interrupt request |
| irq_en | input | 1 | Interrupt enable; requests count only when high |
| irq_ack | output | 1 | One-cycle interrupt acknowledge pulse |
| halted | output | 1 | Halted-state flag |
| ret_addr | output | 16 | Return address captured at the last acceptance |
| refresh | output | 8 | Refresh register |

## Verification
The bound checker watches the cycle-to-cycle rules on every clock. These are the address step for ordinary opcodes, the frozen address while halted, the entry into the halted state, refresh counting with bit 7 kept, the single-cycle acknowledge pulse, the vector load and the masking by irq_en. Some behaviours show up only in the bench's scenarios, because they depend on where a long run of fetches leads. These are a halt sitting at 0x7FFF whose dummy fetches land on 0x8000, the halt at 0xFFFF that wraps to 0x0000, the exact return address and refresh count seen after a long halted stretch, and a halt that collides with an accepted interrupt. A reference model in the bench follows every random cycle as well.

// File: rtl/halt_seq_pkg.sv
package halt_seq_pkg;

   // Kind of machine cycle the sequencer is running in the current clock.
   typedef enum logic [1:0] {
      CYC_RUN = 2'd0,   // normal opcode fetch and execute
      CYC_NOP = 2'd1,   // halted: fetch performed, byte replaced by no-op
      CYC_ACK = 2'd2    // interrupt acknowledge, no opcode fetch
   } cyc_kind_e;

   function automatic cyc_kind_e classify_cycle(input logic ack_cycle,
                                                input logic halted_now);
      if (ack_cycle)
         return CYC_ACK;
      else if (halted_now)
         return CYC_NOP;
      else
         return CYC_RUN;
   endfunction

endpackage

// File: rtl/halt_seq_decode.sv
module halt_seq_decode
   import halt_seq_pkg::*;
#(
   parameter int unsigned        DATA_W  = 8,
   parameter logic [DATA_W-1:0]  HALT_OP = 8'h76
) (
   input  cyc_kind_e           cyc_kind,
   input  logic [DATA_W-1:0]   op_data,
   output logic                exec_halt
);

   // The opcode byte is only meaningful in a real run cycle; during halted
   // no-op cycles and acknowledge cycles it is discarded.
   logic op_is_halt;

   always_comb begin
      op_is_halt = (op_data == HALT_OP);
      exec_halt  = (cyc_kind == CYC_RUN) && op_is_halt;
   end

endmodule

// File: rtl/halt_seq_pc.sv
module halt_seq_pc
   import halt_seq_pkg::*;
#(
   parameter int unsigned        ADDR_W     = 16,
   parameter logic [ADDR_W-1:0]  IRQ_VECTOR = 16'h0038
) (
   input  logic               clk,
   input  logic               rst,
   input  cyc_kind_e          cyc_kind,
   input  logic               take_irq,
   output logic [ADDR_W-1:0]  pc_q,
   output logic [ADDR_W-1:0]  pc_follow
);

   localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

   // Address that follows the cycle now completing. A halted no-op cycle
   // does not advance; a halt in a run cycle advances like any other byte.
   always_comb begin
      unique case (cyc_kind)
         CYC_RUN: pc_follow = pc_q + ADDR_ONE;
         CYC_NOP: pc_follow = pc_q;
         default: pc_follow = pc_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)
         pc_q <= '0;
      else if (take_irq)
         pc_q <= IRQ_VECTOR;
      else if (cyc_kind != CYC_ACK)
         pc_q <= pc_follow;
   end

endmodule

// File: rtl/halt_seq_refresh.sv
module halt_seq_refresh #(
   parameter int unsigned W     = 8,
   parameter int unsigned CNT_W = 7
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          tick,
   output logic [W-1:0]  r_q
);

   logic [W-1:0] r_next;

   generate
      if (CNT_W == W) begin : g_full
         // Whole register counts.
         always_comb r_next = r_q + W'(1);
      end else begin : g_split
         // Only the low field counts; the upper bits are carried unchanged.
         logic [CNT_W-1:0] low_inc;
         always_comb begin
            low_inc = r_q[CNT_W-1:0] + CNT_W'(1);
            r_next  = {r_q[W-1:CNT_W], low_inc};
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         r_q <= '0;
      else if (tick)
         r_q <= r_next;
   end

endmodule

// File: rtl/halt_seq_irq.sv
module halt_seq_irq
   import halt_seq_pkg::*;
#(
   parameter int unsigned ADDR_W = 16
) (
   input  logic               clk,
   input  logic               rst,
   input  cyc_kind_e          cyc_kind,
   input  logic               irq_req,
   input  logic               irq_en,
   input  logic [ADDR_W-1:0]  pc_follow,
   output logic               take_irq,
   output logic               ack_q,
   output logic [ADDR_W-1:0]  ret_q
);

   // Requests are sampled at the end of each fetch cycle, never during the
   // acknowledge cycle itself.
   always_comb take_irq = (cyc_kind != CYC_ACK) && irq_req && irq_en;

   always_ff @(posedge clk) begin
      if (rst) begin
         ack_q <= 1'b0;
         ret_q <= '0;
      end else begin
         ack_q <= take_irq;
         if (take_irq)
            ret_q <= pc_follow;
      end
   end

endmodule

// File: rtl/halt_fetch_seq.sv
module halt_fetch_seq
   import halt_seq_pkg::*;
#(
   parameter int unsigned        ADDR_W        = 16,
   parameter int unsigned        DATA_W        = 8,
   parameter int unsigned        REFRESH_CNT_W = 7,
   parameter logic [DATA_W-1:0]  HALT_OP       = 8'h76,
   parameter logic [ADDR_W-1:0]  IRQ_VECTOR    = 16'h0038
) (
   input  logic               clk,
   input  logic               rst,
   output logic [ADDR_W-1:0]  fetch_addr,
   output logic               fetch_rd,
   input  logic [DATA_W-1:0]  op_data,
   input  logic               irq_req,
   input  logic               irq_en,
   output logic               irq_ack,
   output logic               halted,
   output logic [ADDR_W-1:0]  ret_addr,
   output logic [DATA_W-1:0]  refresh
);

   // Elaboration-time parameter checks.
   if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr_w
      $error("halt_fetch_seq: ADDR_W out of range");
   end
   if (DATA_W < 2) begin : g_bad_data_w
      $error("halt_fetch_seq: DATA_W too small");
   end
   if (REFRESH_CNT_W < 1 || REFRESH_CNT_W > DATA_W) begin : g_bad_cnt_w
      $error("halt_fetch_seq: REFRESH_CNT_W must lie in 1..DATA_W");
   end

   cyc_kind_e          cyc_kind;
   logic               halted_q;
   logic               exec_halt;
   logic               take_irq;
   logic               ack_q;
   logic [ADDR_W-1:0]  pc_q;
   logic [ADDR_W-1:0]  pc_follow;
   logic [ADDR_W-1:0]  ret_q;
   logic [DATA_W-1:0]  r_q;

   always_comb cyc_kind = classify_cycle(ack_q, halted_q);

   halt_seq_decode #(
      .DATA_W  (DATA_W),
      .HALT_OP (HALT_OP)
   ) u_decode (
      .cyc_kind  (cyc_kind),
      .op_data   (op_data),
      .exec_halt (exec_halt)
   );

   halt_seq_pc #(
      .ADDR_W     (ADDR_W),
      .IRQ_VECTOR (IRQ_VECTOR)
   ) u_pc (
      .clk       (clk),
      .rst       (rst),
      .cyc_kind  (cyc_kind),
      .take_irq  (take_irq),
      .pc_q      (pc_q),
      .pc_follow (pc_follow)
   );

   halt_seq_irq #(
      .ADDR_W (ADDR_W)
   ) u_irq (
      .clk       (clk),
      .rst       (rst),
      .cyc_kind  (cyc_kind),
      .irq_req   (irq_req),
      .irq_en    (irq_en),
      .pc_follow (pc_follow),
      .take_irq  (take_irq),
      .ack_q     (ack_q),
      .ret_q     (ret_q)
   );

   halt_seq_refresh #(
      .W     (DATA_W),
      .CNT_W (REFRESH_CNT_W)
   ) u_refresh (
      .clk  (clk),
      .rst  (rst),
      .tick (cyc_kind != CYC_ACK),
      .r_q  (r_q)
   );

   // Halted flag: an accepted interrupt takes priority over a halt executed
   // in the same cycle.
   always_ff @(posedge clk) begin
      if (rst)
         halted_q <= 1'b0;
      else if (take_irq)
         halted_q <= 1'b0;
      else if (exec_halt)
         halted_q <= 1'b1;
   end

   always_comb begin
      fetch_addr = pc_q;
      fetch_rd   = (cyc_kind != CYC_ACK);
      irq_ack    = ack_q;
      halted     = halted_q;
      ret_addr   = ret_q;
      refresh    = r_q;
   end

endmodule

// File: rtl/halt_fetch_seq_chk.sv
module halt_fetch_seq_chk #(
   parameter int unsigned        ADDR_W        = 16,
   parameter int unsigned        DATA_W        = 8,
   parameter int unsigned        REFRESH_CNT_W = 7,
   parameter logic [DATA_W-1:0]  HALT_OP       = 8'h76,
   parameter logic [ADDR_W-1:0]  IRQ_VECTOR    = 16'h0038
) (
   input logic               clk,
   input logic               rst,
   input logic [ADDR_W-1:0]  fetch_addr,
   input logic               fetch_rd,
   input logic [DATA_W-1:0]  op_data,
   input logic               irq_req,
   input logic               irq_en,
   input logic               irq_ack,
   input logic               halted,
   input logic [ADDR_W-1:0]  ret_addr,
   input logic [DATA_W-1:0]  refresh
);

   logic accept;
   always_comb accept = fetch_rd && irq_req && irq_en;

   // R2: ordinary opcode steps the address by one
   a_r2_step_one: assert property (@(posedge clk) disable iff (rst)
      (fetch_rd && !halted && op_data != HALT_OP && !accept)
      |=> fetch_addr == ADDR_W'($past(fetch_addr) + 1'b1));

   // R3: halt opcode enters halted state one byte further on
   a_r3_halt_enter: assert property (@(posedge clk) disable iff (rst)
      (fetch_rd && !halted && op_data == HALT_OP && !accept)
      |=> halted && fetch_addr == ADDR_W'($past(fetch_addr) + 1'b1));

   // R4: dummy fetches keep the same address
   a_r4_halt_holds_addr: assert property (@(posedge clk) disable iff (rst)
      (fetch_rd && halted && !accept) |=> $stable(fetch_addr) && halted);

   // R6: low refresh field counts per fetch, top bit kept
   a_r6_refresh_count: assert property (@(posedge clk) disable iff (rst)
      fetch_rd |=> (refresh[REFRESH_CNT_W-1:0] ==
                    REFRESH_CNT_W'($past(refresh[REFRESH_CNT_W-1:0]) + 1'b1))
                   && refresh[DATA_W-1] == $past(refresh[DATA_W-1]));

   // R6: acknowledge cycles leave refresh alone
   a_r6_refresh_ack_hold: assert property (@(posedge clk) disable iff (rst)
      !fetch_rd |=> $stable(refresh));

   // R7: acceptance leads to acknowledge with halted cleared
   a_r7_accept: assert property (@(posedge clk) disable iff (rst)
      accept |=> irq_ack && !fetch_rd && !halted);

   // R7: acknowledge is a single-cycle pulse
   a_r7_ack_single: assert property (@(posedge clk) disable iff (rst)
      irq_ack |=> !irq_ack && fetch_rd);

   // R8: vector is on the address bus during acknowledge
   a_r8_vector: assert property (@(posedge clk) disable iff (rst)
      irq_ack |-> fetch_addr == IRQ_VECTOR);

   // R9: masked request does not acknowledge
   a_r9_masked: assert property (@(posedge clk) disable iff (rst)
      (fetch_rd && !irq_en) |=> !irq_ack);

   // R7: return address only changes on acknowledge
   a_r7_ret_hold: assert property (@(posedge clk) disable iff (rst)
      !irq_ack |-> $stable(ret_addr));

endmodule

bind halt_fetch_seq halt_fetch_seq_chk #(
   .ADDR_W        (ADDR_W),
   .DATA_W        (DATA_W),
   .REFRESH_CNT_W (REFRESH_CNT_W),
   .HALT_OP       (HALT_OP),
   .IRQ_VECTOR    (IRQ_VECTOR)
) chk_i (
   .clk        (clk),
   .rst        (rst),
   .fetch_addr (fetch_addr),
   .fetch_rd   (fetch_rd),
   .op_data    (op_data),
   .irq_req    (irq_req),
   .irq_en     (irq_en),
   .irq_ack    (irq_ack),
   .halted     (halted),
   .ret_addr   (ret_addr),
   .refresh    (refresh)
);

// File: tb/halt_fetch_seq_tb_top.sv
module halt_fetch_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] fetch_addr;
   logic        fetch_rd;
   logic [7:0]  op_data = 8'h00;
   logic        irq_req = 1'b0;
   logic        irq_en  = 1'b0;
   logic        irq_ack;
   logic        halted;
   logic [15:0] ret_addr;
   logic [7:0]  refresh;

   always #4 clk = ~clk;   // 125 MHz

   halt_fetch_seq dut_i (
      .clk        (clk),
      .rst        (rst),
      .fetch_addr (fetch_addr),
      .fetch_rd   (fetch_rd),
      .op_data    (op_data),
      .irq_req    (irq_req),
      .irq_en     (irq_en),
      .irq_ack    (irq_ack),
      .halted     (halted),
      .ret_addr   (ret_addr),
      .refresh    (refresh)
   );

   int unsigned n_checks = 0;
   int unsigned n_fail   = 0;
   int unsigned cycles   = 0;
   bit          done     = 1'b0;

   // Reference model state
   logic [15:0] m_pc;
   logic        m_halt;
   logic [7:0]  m_r;
   logic        m_ack;
   logic [15:0] m_ret;

   function automatic logic [7:0] refresh_next(input logic [7:0] r);
      return {r[7], 7'(r[6:0] + 7'd1)};
   endfunction

   task automatic chk(input string tag, input logic [31:0] got,
                      input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h (t=%0t)", tag, got, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_pc = 16'h0000; m_halt = 1'b0; m_r = 8'h00; m_ack = 1'b0; m_ret = 16'h0000;
   endtask

   task automatic model_update(input logic [7:0] op, input logic req,
                               input logic en);
      logic [15:0] nxt;
      if (m_ack) begin
         m_ack = 1'b0;
      end else begin
         m_r = refresh_next(m_r);
         nxt = m_halt ? m_pc : 16'(m_pc + 16'd1);
         if (req && en) begin
            m_ret  = nxt;
            m_pc   = 16'h0038;
            m_halt = 1'b0;
            m_ack  = 1'b1;
         end else begin
            if (!m_halt && op == 8'h76) m_halt = 1'b1;
            m_pc = nxt;
         end
      end
   endtask

   task automatic compare_all();
      chk(m_halt ? "R4 addr" : "R2 addr", 32'(fetch_addr), 32'(m_pc));
      chk("R7 fetch_rd", 32'(fetch_rd), 32'(!m_ack));
      chk("R7 ack", 32'(irq_ack), 32'(m_ack));
      chk("R10 halted", 32'(halted), 32'(m_halt));
      chk("R7 ret", 32'(ret_addr), 32'(m_ret));
      chk("R6 refresh", 32'(refresh), 32'(m_r));
   endtask

   // Called at a falling edge: checks, drives, advances one cycle.
   task automatic step(input logic [7:0] op, input logic req, input logic en);
      compare_all();
      op_data = op; irq_req = req; irq_en = en;
      model_update(op, req, en);
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic print_summary();
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
   endtask

   initial begin : watchdog
      while (!done && cycles < 190000) begin
         @(posedge clk);
         cycles++;
      end
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got %0d cycles expected completion", cycles);
         print_summary();
         $finish;
      end
   end

   initial begin : stim
      logic [7:0] r_before;
      void'($urandom(32'd20240607));
      model_reset();
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R1: reset state
      chk("R1 addr", 32'(fetch_addr), 32'h0);
      chk("R1 halted", 32'(halted), 32'h0);
      chk("R1 refresh", 32'(refresh), 32'h0);
      chk("R1 ack", 32'(irq_ack), 32'h0);
      chk("R1 ret", 32'(ret_addr), 32'h0);
      chk("R1 fetch_rd", 32'(fetch_rd), 32'h1);

      // R2: ordinary bytes, even with a masked request
      step(8'h00, 1'b0, 1'b0);
      step(8'h3E, 1'b1, 1'b0);
      step(8'hFF, 1'b0, 1'b1);
      step(8'h12, 1'b0, 1'b0);
      step(8'h00, 1'b0, 1'b0);
      chk("R2 pc after five", 32'(fetch_addr), 32'h5);

      // R3: halt at 0x0005
      step(8'h76, 1'b0, 1'b0);
      chk("R3 halted set", 32'(halted), 32'h1);
      chk("R3 addr after halt", 32'(fetch_addr), 32'h6);

      // R4: dummy fetches ignore data, even another 0x76
      r_before = refresh;
      step(8'h76, 1'b0, 1'b0);
      step(8'hC3, 1'b0, 1'b0);
      step(8'h76, 1'b0, 1'b0);
      chk("R4 addr frozen", 32'(fetch_addr), 32'h6);
      chk("R4 fetch_rd", 32'(fetch_rd), 32'h1);
      chk("R6 refresh +3 halted", 32'(refresh), 32'(refresh_next(refresh_next(refresh_next(r_before)))));

      // R9: masked request while halted
      step(8'h00, 1'b1, 1'b0);
      step(8'h00, 1'b1, 1'b0);
      chk("R9 still halted", 32'(halted), 32'h1);
      chk("R9 addr", 32'(fetch_addr), 32'h6);
      chk("R9 no ack", 32'(irq_ack), 32'h0);

      // R7 / R8: accepted interrupt while halted
      r_before = refresh;
      step(8'h00, 1'b1, 1'b1);
      chk("R7 ack pulse", 32'(irq_ack), 32'h1);
      chk("R7 ret no extra increment", 32'(ret_addr), 32'h6);
      chk("R10 halted cleared", 32'(halted), 32'h0);
      chk("R8 vector on bus", 32'(fetch_addr), 32'h38);
      chk("R7 no fetch in ack", 32'(fetch_rd), 32'h0);
      step(8'h00, 1'b1, 1'b1);   // request during ack is not sampled
      chk("R7 ack single", 32'(irq_ack), 32'h0);
      chk("R8 fetch at vector", 32'(fetch_addr), 32'h38);
      chk("R6 ack no count", 32'(refresh), 32'(refresh_next(r_before)));

      // R11: halt colliding with acceptance
      step(8'h76, 1'b1, 1'b1);
      chk("R11 not halted", 32'(halted), 32'h0);
      chk("R11 ret", 32'(ret_addr), 32'h39);
      step(8'h00, 1'b0, 1'b0);

      // R5: run up to 0x7FFF and halt there
      while (fetch_addr != 16'h7FFF) step(8'h00, 1'b0, 1'b0);
      step(8'h76, 1'b0, 1'b0);
      for (int i = 0; i < 200; i++) begin
         chk("R5 dummy fetch addr", 32'(fetch_addr), 32'h8000);
         step(8'h76, 1'b0, 1'b0);
      end
      r_before = refresh;
      step(8'h00, 1'b1, 1'b1);
      chk("R5 ret after halt at 7FFF", 32'(ret_addr), 32'h8000);
      chk("R6 refresh bit7 kept", 32'(refresh[7]), 32'h0);
      step(8'h00, 1'b0, 1'b0);

      // R3: halt at 0xFFFF wraps
      while (fetch_addr != 16'hFFFF) step(8'h00, 1'b0, 1'b0);
      step(8'h76, 1'b0, 1'b0);
      chk("R3 wrap addr", 32'(fetch_addr), 32'h0);
      chk("R3 wrap halted", 32'(halted), 32'h1);
      step(8'h00, 1'b1, 1'b1);
      chk("R7 ret after wrap", 32'(ret_addr), 32'h0);

      // Constrained random mix, followed by the model every cycle
      for (int i = 0; i < 4000; i++) begin
         logic [7:0] op;
         op = ($urandom_range(0, 5) == 0) ? 8'h76 : 8'($urandom());
         step(op, $urandom_range(0, 7) == 0, $urandom_range(0, 3) != 0);
      end
      compare_all();

      done = 1'b1;
      print_summary();
      $finish;
   end

endmodule